// File: doc/BRIEF.md
# NAND Command Sequence Monitor

This block watches the asynchronous control lines and the 8-bit I/O bus of a NAND flash device without driving them. It reports when the traffic on that bus breaks the device's sequencing rules. All bus inputs pass through two synchronising flops into the monitor clock domain. Rising edges of the write strobe and the read strobe are found on the synchronised copies, and each one is classified as a command, address, data-in or data-out cycle.

A rule engine then follows the command stream. It enforces these rules:
- Only defined command bytes may be issued.
- After an 11h command and up to the next 81h, only a short whitelist of commands is allowed.
- While ready/busy is low, only a short whitelist of commands is allowed.
- In interleaved two-chip mode, the plain status command 70h is forbidden.
- Multi-plane groups must keep the same plane order.
- A cache sequence must stay inside one block.

Each offending bus cycle produces one error pulse with a code for the rule broken. A set of sticky flags records every rule broken since the flags were last cleared.

Top module: `nand_seq_monitor`

## Requirements
- R1: A bus cycle is recognised only while the chip-enable line is low. On a rising write-strobe edge it is a command when the command latch is 1 and the address latch is 0. It is an address when the address latch is 1 and the command latch is 0. It is a data-in cycle when both latches are 0. A rising read-strobe edge with both latches 0 is a data-out cycle. Nothing else is a cycle.
- R2: A command byte outside the set {00, 05, 10, 11, 15, 30, 31, 35, 3F, 60, 70, 78, 80, 81, 85, 90, D0, E0, FF} (hex) breaks rule 1.
- R3: An 11h command opens a window, and an 81h or FFh command closes it. A command other than 70h, 78h, FFh or 81h issued while the window is open breaks rule 2.
- R4: While the synchronised ready/busy input is low (busy), a command other than FFh, 70h or 78h breaks rule 3.
- R5: While busy, any address, data-in or data-out cycle breaks rule 4.
- R6: While `ilv_mode` is 1, a 70h command breaks rule 5. 78h remains legal.
- R7: The plane of an address phase is bit 0 of its third address byte. The first 11h after reset records the plane of the latest completed 5-byte address phase. A later 11h whose latest address phase has a different plane breaks rule 6.
- R8: The block of an address phase is its address bytes 3 to 5, with byte 3 least significant. A 15h or 31h command starts a cache sequence holding the latest block. 10h, 3Fh or FFh ends the sequence. A completed address phase with a different block during the sequence breaks rule 7, reported on its fifth byte.
- R9: Each bus cycle that breaks at least one rule gives exactly one single-cycle `err_pulse`. The accompanying `err_code` is the lowest-numbered rule broken. `err_code` is 0 whenever `err_pulse` is low.
- R10: Bit k-1 of `err_flags` becomes 1 when rule k is broken and stays 1. A `flag_clr` pulse clears all flags on the next clock edge.
- R11: After reset, `err_pulse`, `err_code` and `err_flags` are 0, and no window or cache sequence is open.
- R12: An FFh command closes both the 11h window and any cache sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_clr | input | 1 | Synchronous clear of the sticky flags |
| ilv_mode | input | 1 | 1 when two chips are operated interleaved |
| nand_cle | input | 1 | Command latch enable from the bus |
| nand_ale | input | 1 | Address latch enable from the bus |
| nand_ce_n | input | 1 | Chip enable, active low |
| nand_we_n | input | 1 | Write strobe, active low |
| nand_re_n | input | 1 | Read strobe, active low |
| nand_rb_n | input | 1 | Ready/busy, low while busy |
| nand_io | input | 8 | I/O bus |
| err_pulse | output | 1 | One-cycle error indication |
| err_code | output | 4 | Lowest rule number broken (1 to 7) |
| err_flags | output | 7 | Sticky rule flags, bit k-1 for rule k |

## Verification
An undefined command byte issued while ready/busy is low breaks two rules in one bus cycle: the defined-set rule and the busy whitelist. The bench holds ready/busy low and issues 42h. It then expects exactly one single-cycle pulse, code 1 because the lower rule number wins, and sticky flags with bits 0 and 2 both set. The combination of a command in the 11h window while interleaved is covered in the same way through separate scenarios, each judged by pulse count, last code and flag pattern.

// File: rtl/nand_mon_pkg.sv
package nand_mon_pkg;

  localparam int NRULE  = 7;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    E_NONE    = 4'd0,
    E_UNDEF   = 4'd1,
    E_WINDOW  = 4'd2,
    E_BUSYCMD = 4'd3,
    E_BUSYCYC = 4'd4,
    E_ILV     = 4'd5,
    E_PLANE   = 4'd6,
    E_CACHE   = 4'd7
  } err_e;

  function automatic logic cmd_known(input logic [7:0] c);
    logic k;
    case (c)
      8'h00, 8'h05, 8'h10, 8'h11, 8'h15, 8'h30, 8'h31, 8'h35, 8'h3F,
      8'h60, 8'h70, 8'h78, 8'h80, 8'h81, 8'h85, 8'h90, 8'hD0, 8'hE0,
      8'hFF:   k = 1'b1;
      default: k = 1'b0;
    endcase
    return k;
  endfunction

  // lowest set rule index wins, reported as index+1
  function automatic logic [CODE_W-1:0] first_rule(input logic [NRULE-1:0] v);
    logic [CODE_W-1:0] r;
    r = '0;
    for (int i = NRULE - 1; i >= 0; i--) begin
      if (v[i]) r = CODE_W'(i + 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/nand_bus_sync.sv
module nand_bus_sync #(
  parameter int             W       = 14,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_async[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end

endmodule

// File: rtl/nand_cycle_class.sv
module nand_cycle_class (
  input  logic clk,
  input  logic rst_n,
  input  logic cle,
  input  logic ale,
  input  logic ce_n,
  input  logic we_n,
  input  logic re_n,
  output logic cmd_stb,
  output logic addr_stb,
  output logic din_stb,
  output logic dout_stb
);

  logic we_prev_q, re_prev_q;
  logic we_rise, re_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev_q <= 1'b1;
      re_prev_q <= 1'b1;
    end else begin
      we_prev_q <= we_n;
      re_prev_q <= re_n;
    end
  end

  always_comb begin
    we_rise  = we_n & ~we_prev_q;
    re_rise  = re_n & ~re_prev_q;
    cmd_stb  = we_rise & ~ce_n &  cle & ~ale;
    addr_stb = we_rise & ~ce_n & ~cle &  ale;
    din_stb  = we_rise & ~ce_n & ~cle & ~ale;
    dout_stb = re_rise & ~ce_n & ~cle & ~ale;
  end

  assert_single_cmd_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);
  assert_single_addr_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |=> !addr_stb);

endmodule

// File: rtl/nand_seq_rules.sv
module nand_seq_rules
  import nand_mon_pkg::*;
#(
  parameter int DW     = 8,
  parameter int ACYC   = 5,
  parameter int BLK_LO = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_stb,
  input  logic             addr_stb,
  input  logic             din_stb,
  input  logic             dout_stb,
  input  logic [DW-1:0]    io,
  input  logic             busy,
  input  logic             ilv,
  output logic [NRULE-1:0] hit
);

  localparam int BW  = DW * (ACYC - BLK_LO + 1);
  localparam int ACW = $clog2(ACYC + 1);

  logic           win_q, win_n;
  logic           cache_q, cache_n;
  logic [BW-1:0]  cache_blk_q, cache_blk_n;
  logic [ACW-1:0] acnt_q, acnt_n;
  logic [BW-1:0]  acc_q, acc_n;
  logic [BW-1:0]  last_blk_q, last_blk_n;
  logic           ord_vld_q, ord_vld_n;
  logic           ord_plane_q, ord_plane_n;
  logic [BW-1:0]  blk_shift;
  logic           in_blk, last_byte;

  always_comb begin
    blk_shift = {io, acc_q[BW-1:DW]};
    in_blk    = (acnt_q >= ACW'(BLK_LO - 1)) && (acnt_q < ACW'(ACYC));
    last_byte = (acnt_q == ACW'(ACYC - 1));
  end

  // rule checks (index k-1 is rule k)
  always_comb begin
    hit    = '0;
    hit[0] = cmd_stb && !cmd_known(io);
    hit[1] = cmd_stb && win_q &&
             !(io == 8'h70 || io == 8'h78 || io == 8'hFF || io == 8'h81);
    hit[2] = cmd_stb && busy && !(io == 8'hFF || io == 8'h70 || io == 8'h78);
    hit[3] = busy && (addr_stb || din_stb || dout_stb);
    hit[4] = cmd_stb && ilv && (io == 8'h70);
    hit[5] = cmd_stb && (io == 8'h11) && ord_vld_q && (last_blk_q[0] != ord_plane_q);
    hit[6] = addr_stb && last_byte && cache_q && (blk_shift != cache_blk_q);
  end

  // next state
  always_comb begin
    win_n       = win_q;
    cache_n     = cache_q;
    cache_blk_n = cache_blk_q;
    acnt_n      = acnt_q;
    acc_n       = acc_q;
    last_blk_n  = last_blk_q;
    ord_vld_n   = ord_vld_q;
    ord_plane_n = ord_plane_q;
    if (cmd_stb) begin
      acnt_n = '0;
      if (io == 8'h11) win_n = 1'b1;
      if (io == 8'h81 || io == 8'hFF) win_n = 1'b0;
      if ((io == 8'h15 || io == 8'h31) && !cache_q) begin
        cache_n     = 1'b1;
        cache_blk_n = last_blk_q;
      end
      if (io == 8'h10 || io == 8'h3F || io == 8'hFF) cache_n = 1'b0;
      if (io == 8'h11 && !ord_vld_q) begin
        ord_vld_n   = 1'b1;
        ord_plane_n = last_blk_q[0];
      end
    end else if (addr_stb) begin
      if (acnt_q < ACW'(ACYC)) acnt_n = acnt_q + 1'b1;
      if (in_blk) acc_n = blk_shift;
      if (last_byte) last_blk_n = blk_shift;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q       <= 1'b0;
      cache_q     <= 1'b0;
      cache_blk_q <= '0;
      acnt_q      <= '0;
      acc_q       <= '0;
      last_blk_q  <= '0;
      ord_vld_q   <= 1'b0;
      ord_plane_q <= 1'b0;
    end else begin
      win_q       <= win_n;
      cache_q     <= cache_n;
      cache_blk_q <= cache_blk_n;
      acnt_q      <= acnt_n;
      acc_q       <= acc_n;
      last_blk_q  <= last_blk_n;
      ord_vld_q   <= ord_vld_n;
      ord_plane_q <= ord_plane_n;
    end
  end

  assert_ff_closes_all_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && io == 8'hFF) |=> (!win_q && !cache_q));
  assert_addr_count_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acnt_q <= ACW'(ACYC));
  assert_window_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && io == 8'h11) |=> win_q);

endmodule

// File: rtl/nand_seq_monitor.sv
module nand_seq_monitor
  import nand_mon_pkg::*;
#(
  parameter int DW     = 8,
  parameter int ACYC   = 5,
  parameter int BLK_LO = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_clr,
  input  logic              ilv_mode,
  input  logic              nand_cle,
  input  logic              nand_ale,
  input  logic              nand_ce_n,
  input  logic              nand_we_n,
  input  logic              nand_re_n,
  input  logic              nand_rb_n,
  input  logic [DW-1:0]     nand_io,
  output logic              err_pulse,
  output logic [CODE_W-1:0] err_code,
  output logic [NRULE-1:0]  err_flags
);

  localparam int           SW   = DW + 6;
  localparam logic [SW-1:0] SRST = {4'b1111, {(DW + 2){1'b0}}};

  logic [SW-1:0]     s_bus;
  logic [DW-1:0]     s_io;
  logic              s_cle, s_ale, s_ce_n, s_we_n, s_re_n, s_rb_n;
  logic              cmd_stb, addr_stb, din_stb, dout_stb;
  logic [NRULE-1:0]  hit;
  logic              pulse_q, pulse_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic [NRULE-1:0]  flags_q, flags_n;

  nand_bus_sync #(.W(SW), .RST_VAL(SRST)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({nand_rb_n, nand_re_n, nand_we_n, nand_ce_n, nand_ale, nand_cle, nand_io}),
    .q       (s_bus)
  );

  assign {s_rb_n, s_re_n, s_we_n, s_ce_n, s_ale, s_cle, s_io} = s_bus;

  nand_cycle_class u_class (
    .clk      (clk),
    .rst_n    (rst_n),
    .cle      (s_cle),
    .ale      (s_ale),
    .ce_n     (s_ce_n),
    .we_n     (s_we_n),
    .re_n     (s_re_n),
    .cmd_stb  (cmd_stb),
    .addr_stb (addr_stb),
    .din_stb  (din_stb),
    .dout_stb (dout_stb)
  );

  nand_seq_rules #(.DW(DW), .ACYC(ACYC), .BLK_LO(BLK_LO)) u_rules (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_stb  (cmd_stb),
    .addr_stb (addr_stb),
    .din_stb  (din_stb),
    .dout_stb (dout_stb),
    .io       (s_io),
    .busy     (~s_rb_n),
    .ilv      (ilv_mode),
    .hit      (hit)
  );

  always_comb begin
    pulse_n = |hit;
    code_n  = first_rule(hit);
    flags_n = flag_clr ? '0 : (flags_q | hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      code_q  <= '0;
      flags_q <= '0;
    end else begin
      pulse_q <= pulse_n;
      code_q  <= code_n;
      flags_q <= flags_n;
    end
  end

  assign err_pulse = pulse_q;
  assign err_code  = code_q;
  assign err_flags = flags_q;

  assert_code_with_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_code != '0 && err_code <= CODE_W'(NRULE)));
  assert_code_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse |-> (err_code == '0));
  assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));
  assert_flags_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (err_flags == '0));

endmodule

// File: tb/sim_nand_seq_monitor.sv
`timescale 1ns/1ps
module sim_nand_seq_monitor;

  logic       clk, rst_n, flag_clr, ilv_mode;
  logic       cle, ale, ce_n, we_n, re_n, rb_n;
  logic [7:0] io;
  logic       err_pulse;
  logic [3:0] err_code;
  logic [6:0] err_flags;

  int ntest = 0, nfail = 0;
  int nrise = 0, nhi = 0, r0 = 0, h0 = 0;
  logic [3:0] last_code = 4'd0;
  logic prev_p = 1'b0;

  nand_seq_monitor u0 (
    .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr), .ilv_mode(ilv_mode),
    .nand_cle(cle), .nand_ale(ale), .nand_ce_n(ce_n), .nand_we_n(we_n),
    .nand_re_n(re_n), .nand_rb_n(rb_n), .nand_io(io),
    .err_pulse(err_pulse), .err_code(err_code), .err_flags(err_flags)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (err_pulse) begin
        nhi++;
        last_code = err_code;
        if (!prev_p) nrise++;
      end
      prev_p = err_pulse;
    end
  end

  task automatic chk(string tag, int act, int exp);
    ntest++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mark();
    r0 = nrise;
    h0 = nhi;
  endtask

  task automatic expect_err(string tag, int n, int code, int flags);
    repeat (8) @(negedge clk);
    chk({tag, " pulses"}, nrise - r0, n);
    if (n > 0) chk({tag, " code"}, int'(last_code), code);
    chk({tag, " flags"}, int'(err_flags), flags);
    chk({tag, " width R9"}, nhi - h0, nrise - r0);
    mark();
  endtask

  task automatic bcyc_ce(logic ce, logic c, logic a, logic [7:0] b);
    @(negedge clk);
    cle = c; ale = a; io = b; ce_n = ce;
    repeat (3) @(negedge clk);
    we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
    cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
  endtask

  task automatic cmd(logic [7:0] b);
    bcyc_ce(1'b0, 1'b1, 1'b0, b);
  endtask

  task automatic din(logic [7:0] b);
    bcyc_ce(1'b0, 1'b0, 1'b0, b);
  endtask

  task automatic addr5(logic [23:0] blk);
    bcyc_ce(1'b0, 1'b0, 1'b1, 8'h00);
    bcyc_ce(1'b0, 1'b0, 1'b1, 8'h00);
    bcyc_ce(1'b0, 1'b0, 1'b1, blk[7:0]);
    bcyc_ce(1'b0, 1'b0, 1'b1, blk[15:8]);
    bcyc_ce(1'b0, 1'b0, 1'b1, blk[23:16]);
  endtask

  task automatic rdcyc();
    @(negedge clk);
    cle = 1'b0; ale = 1'b0;
    re_n = 1'b0;
    repeat (3) @(negedge clk);
    re_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    repeat (2) @(negedge clk);
    mark();
  endtask

  task automatic t_reset();
    chk("R11 pulse after reset", int'(err_pulse), 0);
    chk("R11 code after reset", int'(err_code), 0);
    chk("R11 flags after reset", int'(err_flags), 0);
  endtask

  task automatic t_legal();
    mark();
    cmd(8'h00); addr5(24'h000004); cmd(8'h30);
    rdcyc(); rdcyc();
    cmd(8'h80); addr5(24'h000004); din(8'h42); din(8'h5A); cmd(8'h10);
    cmd(8'h70); rdcyc();
    expect_err("R1 legal traffic, 42h as data", 0, 0, 0);
  endtask

  task automatic t_ce_ignore();
    bcyc_ce(1'b1, 1'b1, 1'b0, 8'h42);
    expect_err("R1 chip-enable high ignored", 0, 0, 0);
  endtask

  task automatic t_undef();
    cmd(8'h42);
    expect_err("R2 undefined command", 1, 1, 7'h01);
    clear_flags();
  endtask

  task automatic t_window();
    cmd(8'h80); addr5(24'h000000); cmd(8'h11);
    expect_err("R3 window open quiet", 0, 0, 0);
    cmd(8'h90);
    expect_err("R3 90h inside window", 1, 2, 7'h02);
    cmd(8'h70); cmd(8'h78);
    expect_err("R3 status inside window", 0, 0, 7'h02);
    cmd(8'h81); cmd(8'h90);
    expect_err("R3 90h after 81h", 0, 0, 7'h02);
    clear_flags();
  endtask

  task automatic t_ff_clears();
    cmd(8'h80); addr5(24'h000000); cmd(8'h11); cmd(8'hFF); cmd(8'h90);
    expect_err("R12 FFh closes window", 0, 0, 0);
    cmd(8'h80); addr5(24'h000100); cmd(8'h15); cmd(8'hFF);
    cmd(8'h80); addr5(24'h000200);
    expect_err("R12 FFh ends cache sequence", 0, 0, 0);
    cmd(8'h10);
  endtask

  task automatic t_busy();
    @(negedge clk); rb_n = 1'b0;
    repeat (4) @(negedge clk);
    cmd(8'h70); cmd(8'h78); cmd(8'hFF);
    expect_err("R4 whitelisted commands while busy", 0, 0, 0);
    cmd(8'h00);
    expect_err("R4 read command while busy", 1, 3, 7'h04);
    bcyc_ce(1'b0, 1'b0, 1'b1, 8'h00);
    expect_err("R5 address while busy", 1, 4, 7'h0C);
    din(8'h11);
    expect_err("R5 data-in while busy", 1, 4, 7'h0C);
    rdcyc();
    expect_err("R5 data-out while busy", 1, 4, 7'h0C);
    @(negedge clk); rb_n = 1'b1;
    repeat (4) @(negedge clk);
    cmd(8'hFF);
    mark();
    clear_flags();
  endtask

  task automatic t_ilv();
    ilv_mode = 1'b1;
    cmd(8'h78);
    expect_err("R6 78h in interleave", 0, 0, 0);
    cmd(8'h70);
    expect_err("R6 70h in interleave", 1, 5, 7'h10);
    ilv_mode = 1'b0;
    cmd(8'h70);
    expect_err("R6 70h not interleaved", 0, 0, 7'h10);
    clear_flags();
  endtask

  task automatic t_plane();
    cmd(8'h80); addr5(24'h000002); cmd(8'h11);
    cmd(8'h81); addr5(24'h000003); cmd(8'h10);
    expect_err("R7 same plane order", 0, 0, 0);
    cmd(8'h80); addr5(24'h000001); cmd(8'h11);
    expect_err("R7 plane order changed", 1, 6, 7'h20);
    cmd(8'h81); addr5(24'h000000); cmd(8'h10);
    expect_err("R7 cleanup", 0, 0, 7'h20);
    clear_flags();
  endtask

  task automatic t_cache();
    cmd(8'h80); addr5(24'h000010); cmd(8'h15);
    cmd(8'h80); addr5(24'h000010); cmd(8'h15);
    expect_err("R8 same block in cache", 0, 0, 0);
    cmd(8'h80); addr5(24'h010010);
    expect_err("R8 block change in cache", 1, 7, 7'h40);
    cmd(8'h10);
    cmd(8'h80); addr5(24'h000030); cmd(8'h10);
    expect_err("R8 after cache end", 0, 0, 7'h40);
    clear_flags();
  endtask

  task automatic t_combined();
    @(negedge clk); rb_n = 1'b0;
    repeat (4) @(negedge clk);
    cmd(8'h42);
    expect_err("R9 undefined while busy", 1, 1, 7'h05);
    @(negedge clk); rb_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_clear();
    clear_flags();
    chk("R10 flags cleared", int'(err_flags), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flag_clr = 1'b0; ilv_mode = 1'b0;
    cle = 1'b0; ale = 1'b0; ce_n = 1'b0; we_n = 1'b1; re_n = 1'b1; rb_n = 1'b1;
    io = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_legal();
    t_ce_ignore();
    t_undef();
    t_window();
    t_ff_clears();
    t_busy();
    t_ilv();
    t_plane();
    t_cache();
    t_combined();
    t_clear();
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

endmodule